// File: doc/BRIEF.md
# Panel Power Sequencer

This block steps a small display controller through its power-up and power-down command lists. It sits in front of a serial command writer. It offers one register write at a time and waits for the writer to report that the write has finished. After some entries it then holds a fixed pause before the next entry. The command lists are a fixed table. Each entry gives a register address, zero to two payload bytes, and a flag that asks for a pause of `GAP_MS` milliseconds after the write.

After reset the block waits for the panel to settle before it serves any request. An enable request runs the power-up list and a disable request runs the power-down list. A request that repeats the current state is dropped. A request that arrives while a list is running is held and served when the list ends. If the writer reports a failed write, the list still runs to the end. The failures are ORed together and folded into a sticky error flag when the list completes.

The command port follows valid/ready rules. While `cmd_valid` is high and `cmd_ready` is low, the writer may stall, and the address, byte count and payload stay unchanged. A command is handed over in the cycle where both are high. The writer then pulses `wr_done` once that write has ended, with `wr_fail` qualifying it in the same cycle. No new command is offered until that pulse has arrived.

Top module: `panel_power_seq`

## Requirements
- R1: No command is offered during the first `SETTLE_MS`×`CYCLES_PER_MS` cycles after reset. An enable request that arrives in that window is held and served once the window has passed.
- R2: The power-up list opens with three address-only (`cmd_nbytes`=0) commands to address 0x00. After each of them, at least `CYCLES_PER_MS` cycles pass between its `wr_done` and the next handshake.
- R3: Next come four one-byte writes, with the payload in `cmd_data[7:0]` and the upper byte zero: 0xB0←0x17, 0xBC←0x80, 0x3B←0x00, 0xB0←0x16.
- R4: Next comes a two-byte write 0xB8←0xFFF9, with the first-sent byte in `cmd_data[15:8]`. It is followed by address-only 0x11, and the list ends with address-only 0x29.
- R5: The power-down list is address-only 0x28, then two-byte 0xB8←0x8002, then address-only 0x10, then one-byte 0xB0←0x00.
- R6: At most one command is outstanding. `cmd_valid` stays low from a handshake until the matching `wr_done`. While `cmd_valid` is high and `cmd_ready` is low, the command fields hold steady.
- R7: An enable request while `panel_active` is high, or a disable request while it is low, produces no command and leaves `panel_active` unchanged.
- R8: `panel_active` rises only in the cycle after the `wr_done` of the final power-up command. It falls one cycle after the disable request is taken, before the first power-down command is handed over.
- R9: A write reported with `wr_fail` does not stop the list, and every later entry is still issued.
- R10: `err_sticky` rises only when a list ends in which at least one write failed, never at the failing write itself. It then stays high until reset.
- R11: A request that arrives while a list runs is served after that list completes. Of two requests in the same cycle, the disable request wins. A later request replaces an earlier one that has not yet been served.
- R12: During and straight after reset, `cmd_valid`, `panel_active` and `err_sticky` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | One-cycle power-up request |
| dis_req | input | 1 | One-cycle power-down request |
| cmd_valid | output | 1 | Command offered to the writer |
| cmd_ready | input | 1 | Writer accepts the command |
| cmd_addr | output | 8 | Register address |
| cmd_nbytes | output | 2 | Payload byte count, 0 to 2 |
| cmd_data | output | 16 | Payload; a single byte sits in [7:0], the first of two in [15:8] |
| wr_done | input | 1 | Pulse when the accepted write has ended |
| wr_fail | input | 1 | Qualifies `wr_done`: the write failed |
| panel_active | output | 1 | Panel is powered and displaying |
| err_sticky | output | 1 | A list ended with at least one failed write |

## Verification
The lists are run against a writer model that stalls `cmd_ready` for zero, one or two cycles, so the command order and field contents must survive back-pressure. Three request patterns are used:
- An early enable during settling tells held requests apart from dropped ones.
- Repeated same-state requests tell no-ops apart from re-runs.
- A disable followed by an enable injected mid-list tells queued requests apart from lost ones.

A single failed write in the middle of the power-up list separates errors that abort the list from errors that are accumulated. The error flag is sampled before and after the list ends, which shows whether it is reported late or immediately.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int IDX_W = 4;

  typedef struct packed {
    logic [7:0]  addr;
    logic [1:0]  nbytes;
    logic [15:0] data;
    logic        gap;
  } step_t;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_GAP
  } seq_state_t;

  localparam logic [IDX_W-1:0] UP_FIRST   = 4'd0;
  localparam logic [IDX_W-1:0] UP_LAST    = 4'd9;
  localparam logic [IDX_W-1:0] DOWN_FIRST = 4'd10;
  localparam logic [IDX_W-1:0] DOWN_LAST  = 4'd13;

  function automatic step_t mk(input logic [7:0] a, input logic [1:0] n,
                               input logic [15:0] d, input logic g);
    step_t s;
    s.addr = a; s.nbytes = n; s.data = d; s.gap = g;
    return s;
  endfunction

  function automatic step_t step_at(input logic [IDX_W-1:0] i);
    case (i)
      4'd0, 4'd1, 4'd2: return mk(8'h00, 2'd0, 16'h0000, 1'b1);
      4'd3:  return mk(8'hB0, 2'd1, 16'h0017, 1'b0);
      4'd4:  return mk(8'hBC, 2'd1, 16'h0080, 1'b0);
      4'd5:  return mk(8'h3B, 2'd1, 16'h0000, 1'b0);
      4'd6:  return mk(8'hB0, 2'd1, 16'h0016, 1'b0);
      4'd7:  return mk(8'hB8, 2'd2, 16'hFFF9, 1'b0);
      4'd8:  return mk(8'h11, 2'd0, 16'h0000, 1'b0);
      4'd9:  return mk(8'h29, 2'd0, 16'h0000, 1'b0);
      4'd10: return mk(8'h28, 2'd0, 16'h0000, 1'b0);
      4'd11: return mk(8'hB8, 2'd2, 16'h8002, 1'b0);
      4'd12: return mk(8'h10, 2'd0, 16'h0000, 1'b0);
      4'd13: return mk(8'hB0, 2'd1, 16'h0000, 1'b0);
      default: return mk(8'h00, 2'd0, 16'h0000, 1'b0);
    endcase
  endfunction

endpackage

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
  parameter int CYC_PER_MS = 1000,
  parameter int INIT_MS    = 90,
  parameter int MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] load_ms,
  output logic            expired
);
  localparam int SUB_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CYC_PER_MS - 1);

  logic [MS_W-1:0]  ms_left;
  logic [SUB_W-1:0] sub;

  // Reset preloads the settle interval so no separate start is needed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_left <= MS_W'(INIT_MS);
      sub     <= '0;
    end else if (load) begin
      ms_left <= load_ms;
      sub     <= '0;
    end else if (ms_left != '0) begin
      if (sub == SUB_LAST) begin
        sub     <= '0;
        ms_left <= ms_left - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign expired = (ms_left == '0);
endmodule

// File: rtl/pps_req_hold.sv
module pps_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis_req,
  input  logic take,
  output logic pend_en,
  output logic pend_dis
);
  // Newest request replaces any unserved one; disable wins a tie.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en  <= 1'b0;
      pend_dis <= 1'b0;
    end else if (en_req || dis_req) begin
      pend_en  <= en_req && !dis_req;
      pend_dis <= dis_req;
    end else if (take) begin
      pend_en  <= 1'b0;
      pend_dis <= 1'b0;
    end
  end
endmodule

// File: rtl/pps_step_rom.sv
module pps_step_rom
  import pps_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  always_comb step = step_at(idx);
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import pps_pkg::*;
#(
  parameter int CYCLES_PER_MS = 1000,
  parameter int SETTLE_MS     = 90,
  parameter int GAP_MS        = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_req,
  input  logic        dis_req,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_addr,
  output logic [1:0]  cmd_nbytes,
  output logic [15:0] cmd_data,
  input  logic        wr_done,
  input  logic        wr_fail,
  output logic        panel_active,
  output logic        err_sticky
);
  localparam int MS_W = 8;

  seq_state_t       st;
  logic [IDX_W-1:0] idx, last_idx;
  logic             run_up, seq_err;
  step_t            cur;
  logic             pend_en, pend_dis, take;
  logic             tmr_load, tmr_expired;
  logic             advance, err_acc;

  pps_step_rom u_rom (.idx(idx), .step(cur));

  pps_req_hold u_hold (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .take(take), .pend_en(pend_en), .pend_dis(pend_dis)
  );

  pps_ms_timer #(.CYC_PER_MS(CYCLES_PER_MS), .INIT_MS(SETTLE_MS), .MS_W(MS_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .load_ms(MS_W'(GAP_MS)), .expired(tmr_expired)
  );

  always_comb begin
    take     = (st == ST_IDLE) && (pend_en || pend_dis);
    tmr_load = (st == ST_WAIT) && wr_done && cur.gap;
    advance  = ((st == ST_WAIT) && wr_done && !cur.gap) ||
               ((st == ST_GAP) && tmr_expired);
    err_acc  = seq_err || ((st == ST_WAIT) && wr_done && wr_fail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_SETTLE;
      idx          <= '0;
      last_idx     <= '0;
      run_up       <= 1'b0;
      seq_err      <= 1'b0;
      panel_active <= 1'b0;
      err_sticky   <= 1'b0;
    end else begin
      case (st)
        ST_SETTLE: if (tmr_expired) st <= ST_IDLE;
        ST_IDLE: begin
          if (pend_en && !panel_active) begin
            idx      <= UP_FIRST;
            last_idx <= UP_LAST;
            run_up   <= 1'b1;
            seq_err  <= 1'b0;
            st       <= ST_ISSUE;
          end else if (pend_dis && panel_active) begin
            idx          <= DOWN_FIRST;
            last_idx     <= DOWN_LAST;
            run_up       <= 1'b0;
            seq_err      <= 1'b0;
            panel_active <= 1'b0;
            st           <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (cmd_ready) st <= ST_WAIT;
        ST_WAIT: begin
          if (wr_done) begin
            seq_err <= err_acc;
            if (cur.gap) st <= ST_GAP;
          end
        end
        ST_GAP: ;
        default: st <= ST_IDLE;
      endcase

      if (advance) begin
        if (idx == last_idx) begin
          err_sticky   <= err_sticky || err_acc;
          panel_active <= run_up;
          st           <= ST_IDLE;
        end else begin
          idx <= idx + 1'b1;
          st  <= ST_ISSUE;
        end
      end
    end
  end

  assign cmd_valid  = (st == ST_ISSUE);
  assign cmd_addr   = cur.addr;
  assign cmd_nbytes = cur.nbytes;
  assign cmd_data   = cur.data;
endmodule

// File: rtl/pps_checks.sv
module pps_checks #(
  parameter int CYCLES_PER_MS = 1000,
  parameter int SETTLE_MS     = 90
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_addr,
  input logic [1:0]  cmd_nbytes,
  input logic [15:0] cmd_data,
  input logic        wr_done,
  input logic        panel_active,
  input logic        err_sticky
);
  localparam int SETTLE_CYC = CYCLES_PER_MS * SETTLE_MS;

  int   since_rst;
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst   <= 0;
      outstanding <= 1'b0;
    end else begin
      if (since_rst < SETTLE_CYC) since_rst <= since_rst + 1;
      if (cmd_valid && cmd_ready) outstanding <= 1'b1;
      else if (wr_done)           outstanding <= 1'b0;
    end
  end

  assert_settle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (since_rst >= SETTLE_CYC));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                   $stable(cmd_nbytes) && $stable(cmd_data)));

  assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !cmd_valid);

  assert_active_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_active) |-> $past(wr_done));

  assert_err_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> $past(wr_done));

  assert_err_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

bind panel_power_seq pps_checks #(
  .CYCLES_PER_MS(CYCLES_PER_MS), .SETTLE_MS(SETTLE_MS)
) u_pps_checks (.*);

// File: tb/test_panel_power_seq.sv
module test_panel_power_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 4;
  localparam int SETTLE     = 90;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, en_req, dis_req, cmd_valid, cmd_ready, wr_done, wr_fail;
  logic panel_active, err_sticky;
  logic [7:0]  cmd_addr;
  logic [1:0]  cmd_nbytes;
  logic [15:0] cmd_data;

  panel_power_seq #(.CYCLES_PER_MS(CPM), .SETTLE_MS(SETTLE), .GAP_MS(1)) i_panel_power_seq (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_nbytes(cmd_nbytes), .cmd_data(cmd_data), .wr_done(wr_done),
    .wr_fail(wr_fail), .panel_active(panel_active), .err_sticky(err_sticky)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0]  lg_addr [0:63];
  logic [1:0]  lg_nb   [0:63];
  logic [15:0] lg_data [0:63];
  int lg_acc [0:63];
  int lg_done[0:63];
  int log_n = 0, fail_idx = -1, stall_left = 0, r6_bad = 0;
  int n_chk = 0, n_fail = 0, rel_cyc = 0;
  bit finished = 0;

  // Writer model: stalls 0..2 cycles, accepts, then reports completion.
  initial begin
    cmd_ready = 0; wr_done = 0; wr_fail = 0;
    forever begin
      @(negedge clk);
      if (wr_done) begin
        wr_done = 0; wr_fail = 0; stall_left = log_n % 3;
      end else if (cmd_ready) begin
        cmd_ready = 0;
        if (cmd_valid) r6_bad++;
        wr_done = 1;
        wr_fail = ((log_n - 1) == fail_idx);
        lg_done[log_n-1] = cyc;
      end else if (cmd_valid) begin
        if (stall_left > 0) stall_left--;
        else if (log_n < 64) begin
          cmd_ready = 1;
          lg_addr[log_n] = cmd_addr; lg_nb[log_n] = cmd_nbytes;
          lg_data[log_n] = cmd_data; lg_acc[log_n] = cyc;
          log_n++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected lists written from the requirements: {addr, nbytes, data}.
  function automatic logic [25:0] want(input int k);
    case (k)
      0, 1, 2: return {8'h00, 2'd0, 16'h0000};
      3:  return {8'hB0, 2'd1, 16'h0017};
      4:  return {8'hBC, 2'd1, 16'h0080};
      5:  return {8'h3B, 2'd1, 16'h0000};
      6:  return {8'hB0, 2'd1, 16'h0016};
      7:  return {8'hB8, 2'd2, 16'hFFF9};
      8:  return {8'h11, 2'd0, 16'h0000};
      9:  return {8'h29, 2'd0, 16'h0000};
      10: return {8'h28, 2'd0, 16'h0000};
      11: return {8'hB8, 2'd2, 16'h8002};
      12: return {8'h10, 2'd0, 16'h0000};
      default: return {8'hB0, 2'd1, 16'h0000};
    endcase
  endfunction

  task automatic check_list(input int base, input int first, input int cnt, input string req);
    for (int i = 0; i < cnt; i++) begin
      logic [25:0] got;
      got = {lg_addr[base+i], lg_nb[base+i], lg_data[base+i]};
      chk(got == want(first + i), req, int'(got), int'(want(first + i)));
    end
  endtask

  task automatic pulse(input bit up);
    @(negedge clk);
    if (up) en_req = 1; else dis_req = 1;
    @(negedge clk);
    en_req = 0; dis_req = 0;
  endtask

  task automatic wait_n(input int target);
    wait (log_n >= target);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!cmd_valid && !panel_active && !err_sticky, "R12 reset state",
        {cmd_valid, panel_active, err_sticky}, 0);
  endtask

  task automatic t_power_up;
    repeat (15) @(negedge clk);
    pulse(1);
    wait (log_n >= 10);
    @(negedge clk);
    chk(panel_active == 0, "R8 active before display-on done", panel_active, 0);
    repeat (12) @(negedge clk);
    chk(lg_acc[0] - rel_cyc >= SETTLE * CPM, "R1 settle respected", lg_acc[0] - rel_cyc, SETTLE * CPM);
    check_list(0, 0, 3, "R2 dummy commands");
    for (int k = 0; k < 3; k++)
      chk(lg_acc[k+1] - lg_done[k] >= CPM, "R2 gap after dummy", lg_acc[k+1] - lg_done[k], CPM);
    check_list(3, 3, 4, "R3 power writes");
    check_list(7, 7, 3, "R4 output, sleep-out, display-on");
    chk(panel_active == 1, "R8 active after power-up", panel_active, 1);
    chk(err_sticky == 0, "R10 no error", err_sticky, 0);
  endtask

  task automatic t_repeat(input bit up);
    int n0;
    logic a0;
    n0 = log_n; a0 = panel_active;
    pulse(up);
    repeat (60) @(negedge clk);
    chk(log_n == n0, "R7 repeat request issues nothing", log_n, n0);
    chk(panel_active == a0, "R7 status unchanged", panel_active, a0);
  endtask

  task automatic t_power_down;
    int base;
    base = log_n;
    pulse(0);
    @(negedge clk);
    chk(panel_active == 0, "R8 active drops at disable start", panel_active, 0);
    chk(log_n == base, "R8 drop precedes first command", log_n, base);
    wait_n(base + 4);
    check_list(base, 10, 4, "R5 power-down list");
  endtask

  task automatic t_fail;
    int base;
    base = log_n;
    fail_idx = base + 4;
    pulse(1);
    wait (log_n >= base + 6);
    @(negedge clk);
    chk(err_sticky == 0, "R10 error not reported mid-list", err_sticky, 0);
    wait_n(base + 10);
    chk(log_n == base + 10, "R9 all entries issued", log_n, base + 10);
    check_list(base, 0, 10, "R9 list intact after failure");
    chk(err_sticky == 1, "R10 error at list end", err_sticky, 1);
    chk(panel_active == 1, "R9 panel still brought up", panel_active, 1);
    fail_idx = -1;
  endtask

  task automatic t_queued;
    int base;
    base = log_n;
    pulse(0);
    wait (log_n >= base + 1);
    pulse(1);
    wait_n(base + 14);
    check_list(base, 10, 4, "R11 running list finishes first");
    check_list(base + 4, 0, 10, "R11 held enable served");
    chk(panel_active == 1, "R11 final state up", panel_active, 1);
    chk(err_sticky == 1, "R10 error stays set", err_sticky, 1);
    chk(r6_bad == 0, "R6 no command while write outstanding", r6_bad, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R11: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; en_req = 0; dis_req = 0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !panel_active && !err_sticky, "R12 in reset",
        {cmd_valid, panel_active, err_sticky}, 0);
    rst_n = 1;
    rel_cyc = cyc;
    t_reset();
    t_power_up();
    t_repeat(1);
    t_power_down();
    t_repeat(0);
    t_fail();
    t_queued();
    finished = 1;
    summary();
    $finish;
  end
endmodule